// File: doc/BRIEF.md
# Charge-Redistribution DAC Phase Sequencer

This block drives the switches of a binary-weighted capacitor DAC that works into an integrating amplifier with offset compensation. When a conversion is requested, it stores the input code and runs two phases. In the first phase, the array is discharged: every capacitor bottom plate is grounded. In the same phase, the amplifier is cut off from the array and closed in unity gain, and the bottom plate of the integrating capacitor is grounded. This stores the amplifier offset on the integrating capacitor. In the second phase, the feedback and grounding switches are released and the amplifier is reconnected to the array. Each capacitor bottom plate then goes to the reference when its code bit is one and stays at ground when the bit is zero. Capacitor i weighs 2^i unit capacitors. One extra unit capacitor stays grounded at all times.

Between the two phases there is a single cycle in which every switch is open. This gives break-before-make behaviour, and it guarantees that the feedback and grounding switches are open before the array switch closes. Outside a conversion, every switch is open, so the held output is left alone. All switch controls are registered levels. A busy flag covers a conversion, and a one-cycle done pulse marks its end. The phase lengths are set by parameters, in clock cycles.

Top module: `cdac_phase_seq`

## Requirements
- R1: After reset, and whenever no conversion is running, all plate selects, the feedback switch, the integrator-ground switch and the array switch are open (0), busy is 0, and the dummy-capacitor ground select is 1.
- R2: A start seen while idle is accepted at that clock edge. From the next cycle, for RESET_CYC cycles, every bit of `plate_gnd_o` is 1 and every bit of `plate_ref_o` is 0, `fb_close_o` and `cint_gnd_o` are 1, and `arr_conn_o` is 0.
- R3: After the discharge phase, exactly one cycle follows in which every plate select and all three amplifier switches are 0. The array switch never closes in a cycle that follows one in which the feedback switch or the integrator-ground switch was closed.
- R4: The charge phase then lasts CHARGE_CYC cycles. For each bit i, `plate_ref_o[i]` equals the captured code bit i and `plate_gnd_o[i]` equals its inverse. `arr_conn_o` is 1, and `fb_close_o` and `cint_gnd_o` are 0.
- R5: The code is sampled only at the accepting edge. Changes on `code_i` after that edge do not affect the plate selects of that conversion.
- R6: `done_o` is 1 for exactly one cycle, the cycle right after the last charge cycle. `busy_o` is 1 from the first discharge cycle through the last charge cycle, and it is 0 while `done_o` is 1.
- R7: A start asserted while busy is ignored. It neither restarts the sequence nor changes the code.
- R8: No plate ever has its reference and ground selects both 1. The array switch is never 1 together with the feedback or integrator-ground switch. `dummy_gnd_o` stays 1.
- R9: A start present in the cycle in which `done_o` is 1 is accepted, so conversions can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Conversion request, sampled while idle |
| code_i | input | CODE_W | Code to convert |
| plate_ref_o | output | CODE_W | Per-capacitor select: bottom plate to reference |
| plate_gnd_o | output | CODE_W | Per-capacitor select: bottom plate to ground |
| dummy_gnd_o | output | 1 | Extra unit capacitor grounded |
| arr_conn_o | output | 1 | Amplifier-to-array switch closed |
| fb_close_o | output | 1 | Amplifier unity-gain feedback switch closed |
| cint_gnd_o | output | 1 | Integrating-capacitor bottom plate grounded |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The hardest cases to reach from the ports are a start that arrives during the done cycle and a start that collides with a running conversion. In the first case the sequencer must relaunch with no idle cycle. In the second, the request and a new code on `code_i` must both leave the running charge pattern untouched. To reach the first, the stimulus holds the request high through a whole conversion. To reach the second, it pulses the request with a different code mid-discharge, and it also changes `code_i` during the charge phase. A behavioural cycle model in the bench predicts every output on every clock, so a missing gap cycle or a phase that is off by one cycle shows up at once.

// File: rtl/cdac_seq_pkg.sv
// Shared types for the capacitor-DAC phase sequencer.
package cdac_seq_pkg;
    // Sequencer phases: idle, discharge/offset store, non-overlap gap, charge.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DIS  = 2'd1,
        PH_GAP  = 2'd2,
        PH_CHG  = 2'd3
    } phase_t;
endpackage

// File: rtl/cdac_phase_ctrl.sv
// Phase controller: steps idle -> discharge -> gap -> charge -> idle.
// Assumes RESET_CYC >= 1 and CHARGE_CYC >= 1. Exposes the next phase so the
// output stage can register switch levels aligned with the phase register.
module cdac_phase_ctrl
    import cdac_seq_pkg::*;
#(
    parameter int RESET_CYC  = 4,
    parameter int CHARGE_CYC = 6
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_i,
    output phase_t phase_nxt_o,
    output logic   accept_o,
    output logic   busy_o,
    output logic   done_o
);
    localparam int MAX_CYC = (RESET_CYC > CHARGE_CYC) ? RESET_CYC : CHARGE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] DIS_LAST = CNT_W'(RESET_CYC - 1);
    localparam logic [CNT_W-1:0] CHG_LAST = CNT_W'(CHARGE_CYC - 1);

    phase_t           phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             done_d, done_q;

    // Next-phase and cycle-count decision.
    always_comb begin
        phase_d  = phase_q;
        cnt_d    = cnt_q;
        accept_o = 1'b0;
        done_d   = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (start_i) begin
                    phase_d  = PH_DIS;
                    cnt_d    = DIS_LAST;
                    accept_o = 1'b1;
                end
            end
            PH_DIS: begin
                if (cnt_q == '0) phase_d = PH_GAP;
                else             cnt_d   = cnt_q - 1'b1;
            end
            PH_GAP: begin
                phase_d = PH_CHG;
                cnt_d   = CHG_LAST;
            end
            PH_CHG: begin
                if (cnt_q == '0) begin
                    phase_d = PH_IDLE;
                    done_d  = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase, counter and done registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            done_q  <= done_d;
        end
    end

    assign phase_nxt_o = phase_d;
    assign busy_o      = (phase_q != PH_IDLE);
    assign done_o      = done_q;
endmodule

// File: rtl/cdac_code_latch.sv
// Code holding register: samples the input code on an accepted request and
// holds it for the whole conversion. Assumes load_i is only high while idle.
module cdac_code_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] code_i,
    output logic [W-1:0] code_o
);
    // Capture on accept, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      code_o <= '0;
        else if (load_i) code_o <= code_i;
    end
endmodule

// File: rtl/cdac_switch_drive.sv
// Switch-level output stage: registers every switch control from the next
// phase, so outputs change on the same edge as the phase register. Plates
// never see both selects at once; the gap phase opens everything.
module cdac_switch_drive
    import cdac_seq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  phase_t       phase_nxt_i,
    input  logic [W-1:0] code_i,
    output logic [W-1:0] plate_ref_o,
    output logic [W-1:0] plate_gnd_o,
    output logic         dummy_gnd_o,
    output logic         arr_conn_o,
    output logic         fb_close_o,
    output logic         cint_gnd_o
);
    // One register pair per capacitor plate.
    for (genvar i = 0; i < W; i++) begin : g_plate
        // Plate i: ground in discharge, code-driven in charge, open otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                plate_ref_o[i] <= 1'b0;
                plate_gnd_o[i] <= 1'b0;
            end else begin
                plate_ref_o[i] <= (phase_nxt_i == PH_CHG) &&  code_i[i];
                plate_gnd_o[i] <= (phase_nxt_i == PH_DIS) ||
                                  ((phase_nxt_i == PH_CHG) && !code_i[i]);
            end
        end
    end

    // Amplifier switches: offset store in discharge, array link in charge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_conn_o <= 1'b0;
            fb_close_o <= 1'b0;
            cint_gnd_o <= 1'b0;
        end else begin
            arr_conn_o <= (phase_nxt_i == PH_CHG);
            fb_close_o <= (phase_nxt_i == PH_DIS);
            cint_gnd_o <= (phase_nxt_i == PH_DIS);
        end
    end

    // Dummy unit capacitor stays grounded in every phase.
    always_ff @(posedge clk) begin
        dummy_gnd_o <= 1'b1;
    end
endmodule

// File: rtl/cdac_phase_seq.sv
// Top of the capacitor-DAC phase sequencer: phase controller, code holding
// register and registered switch drivers. Assumes a single clock domain and
// that the analog array settles within each phase length.
module cdac_phase_seq
    import cdac_seq_pkg::*;
#(
    parameter int CODE_W     = 8,
    parameter int RESET_CYC  = 4,
    parameter int CHARGE_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] plate_ref_o,
    output logic [CODE_W-1:0] plate_gnd_o,
    output logic              dummy_gnd_o,
    output logic              arr_conn_o,
    output logic              fb_close_o,
    output logic              cint_gnd_o,
    output logic              busy_o,
    output logic              done_o
);
    phase_t            phase_nxt;
    logic              accept;
    logic [CODE_W-1:0] code_q;

    cdac_phase_ctrl #(
        .RESET_CYC (RESET_CYC),
        .CHARGE_CYC(CHARGE_CYC)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .phase_nxt_o(phase_nxt),
        .accept_o   (accept),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    cdac_code_latch #(.W(CODE_W)) u_code (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(accept),
        .code_i(code_i),
        .code_o(code_q)
    );

    cdac_switch_drive #(.W(CODE_W)) u_drv (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_nxt_i(phase_nxt),
        .code_i     (code_q),
        .plate_ref_o(plate_ref_o),
        .plate_gnd_o(plate_gnd_o),
        .dummy_gnd_o(dummy_gnd_o),
        .arr_conn_o (arr_conn_o),
        .fb_close_o (fb_close_o),
        .cint_gnd_o (cint_gnd_o)
    );
endmodule

// File: rtl/cdac_seq_chk.sv
// Property checker for the phase sequencer, bound to the top module.
// Observes ports only.
module cdac_seq_chk #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [CODE_W-1:0] code_i,
    input logic [CODE_W-1:0] plate_ref_o,
    input logic [CODE_W-1:0] plate_gnd_o,
    input logic              dummy_gnd_o,
    input logic              arr_conn_o,
    input logic              fb_close_o,
    input logic              cint_gnd_o,
    input logic              busy_o,
    input logic              done_o
);
    // R8
    plate_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (plate_ref_o & plate_gnd_o) == '0);

    // R8
    amp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_close_o || cint_gnd_o) |-> !arr_conn_o);

    // R8
    dummy_tied_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dummy_gnd_o);

    // R3
    break_make_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arr_conn_o) |-> $past(!fb_close_o && !cint_gnd_o && plate_gnd_o == '0));

    // R2
    dis_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_close_o |-> (cint_gnd_o && busy_o && plate_ref_o == '0 && (&plate_gnd_o)));

    // R5
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_conn_o && $past(arr_conn_o)) |-> $stable(plate_ref_o));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(arr_conn_o)));
endmodule

bind cdac_phase_seq cdac_seq_chk #(.CODE_W(CODE_W)) u_seq_chk (.*);

// File: tb/cdac_phase_seq_test.sv
// Bench for the phase sequencer: a behavioural cycle model predicts every
// output and is compared on each falling edge, plus directed checks.
module cdac_phase_seq_test;
    localparam int W    = 8;
    localparam int NDIS = 4;
    localparam int NCHG = 6;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start_i;
    logic [W-1:0] code_i;
    logic [W-1:0] plate_ref_o, plate_gnd_o;
    logic         dummy_gnd_o, arr_conn_o, fb_close_o, cint_gnd_o, busy_o, done_o;

    int total = 0;
    int bad   = 0;

    cdac_phase_seq #(.CODE_W(W), .RESET_CYC(NDIS), .CHARGE_CYC(NCHG)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .code_i(code_i),
        .plate_ref_o(plate_ref_o), .plate_gnd_o(plate_gnd_o),
        .dummy_gnd_o(dummy_gnd_o), .arr_conn_o(arr_conn_o),
        .fb_close_o(fb_close_o), .cint_gnd_o(cint_gnd_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    always #10 clk = ~clk;

    // Behavioural model: mode 0 idle, 1 discharge, 2 gap, 3 charge.
    int           m_mode = 0;
    int           m_left = 0;
    logic [W-1:0] m_code = '0;
    logic         m_done = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_left = 0; m_code = '0; m_done = 1'b0;
        end else begin
            m_done = 1'b0;
            if (m_mode == 0) begin
                if (start_i) begin m_mode = 1; m_left = NDIS; m_code = code_i; end
            end else if (m_mode == 2) begin
                m_mode = 3; m_left = NCHG;
            end else begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    if (m_mode == 1) m_mode = 2;
                    else begin m_mode = 0; m_done = 1'b1; end
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Compare all outputs to the model on every falling edge after reset.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [W-1:0] e_ref, e_gnd;
            logic         e_arr, e_fb, e_busy;
            string        tag;
            e_ref  = (m_mode == 3) ? m_code : '0;
            e_gnd  = (m_mode == 1) ? '1 : ((m_mode == 3) ? ~m_code : '0);
            e_arr  = (m_mode == 3);
            e_fb   = (m_mode == 1);
            e_busy = (m_mode != 0);
            case (m_mode)
                1: tag = "R2";
                2: tag = "R3";
                3: tag = "R4";
                default: tag = m_done ? "R6" : "R1";
            endcase
            check(plate_ref_o == e_ref, tag, "plate_ref", plate_ref_o, e_ref);
            check(plate_gnd_o == e_gnd, tag, "plate_gnd", plate_gnd_o, e_gnd);
            check({arr_conn_o, fb_close_o, cint_gnd_o} == {e_arr, e_fb, e_fb},
                  tag, "amp switches", {arr_conn_o, fb_close_o, cint_gnd_o},
                  {e_arr, e_fb, e_fb});
            check(busy_o == e_busy && done_o == m_done, "R6", "busy/done",
                  {busy_o, done_o}, {e_busy, m_done});
            check((plate_ref_o & plate_gnd_o) == '0 && dummy_gnd_o, "R8",
                  "exclusion/dummy", {dummy_gnd_o, plate_ref_o & plate_gnd_o}, 32'h100);
        end
    end

    task automatic wait_done();
        int n = 0;
        do begin @(negedge clk); n++; end while (!done_o && n < 100);
        #2;
    endtask

    task automatic convert(input logic [W-1:0] c);
        @(negedge clk); #2;
        start_i = 1'b1; code_i = c;
        @(negedge clk); #2;
        start_i = 1'b0;
        wait_done();
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R6: actual=no finish expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; code_i = '0;
        repeat (3) @(negedge clk);
        #2;
        // R1 reset state
        check({plate_ref_o, plate_gnd_o} == '0 && !arr_conn_o && !fb_close_o &&
              !cint_gnd_o && !busy_o && !done_o && dummy_gnd_o, "R1", "reset state",
              {busy_o, arr_conn_o, plate_gnd_o}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        convert(8'hA5);
        convert(8'h00);
        convert(8'hFF);
        convert(8'h01);
        convert(8'h80);

        // R5: code_i changed during charge must not reach the plates
        @(negedge clk); #2; start_i = 1'b1; code_i = 8'h3C;
        @(negedge clk); #2; start_i = 1'b0;
        repeat (NDIS + 2) @(negedge clk);
        #2; code_i = 8'hC3;
        @(negedge clk); @(negedge clk);
        check(plate_ref_o == 8'h3C && arr_conn_o, "R5", "held code", plate_ref_o, 8'h3C);
        wait_done();

        // R7: a start while busy is ignored
        @(negedge clk); #2; start_i = 1'b1; code_i = 8'h5A;
        @(negedge clk); #2; start_i = 1'b0;
        @(negedge clk); #2; start_i = 1'b1; code_i = 8'h0F;
        @(negedge clk); #2; start_i = 1'b0; code_i = 8'h00;
        repeat (NDIS) @(negedge clk);
        check(plate_ref_o == 8'h5A && arr_conn_o, "R7", "code after busy start",
              plate_ref_o, 8'h5A);
        wait_done();
        @(negedge clk);
        check(!busy_o && !fb_close_o, "R7", "no relaunch", busy_o, 0);

        // R9: start held through done relaunches at once
        @(negedge clk); #2; start_i = 1'b1; code_i = 8'h99;
        wait_done();
        @(negedge clk);
        check(busy_o && fb_close_o, "R9", "back-to-back start", {busy_o, fb_close_o}, 3);
        #2; start_i = 1'b0;
        wait_done();
        repeat (3) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule